// File: doc/BRIEF.md
# Serial Controller Host Register File

This block is the processor-side register bank of a classic byte-wide asynchronous serial controller. A host reaches ten registers through a 3-bit address, an 8-bit write bus, an 8-bit read bus and single-cycle read and write strobes. One control bit, held in the top bit of the line control register, decides whether the two lowest addresses reach the data buffers and the interrupt enable, or the two bytes of the baud divisor. The other six addresses always decode the same way.

The block also keeps the pending-interrupt state. Strobes from the receiver and the transmitter set three flags. A change on any modem input pin sets a sticky delta bit, and any delta bit set means a modem-change event is pending. Each source clears through one particular host access. The block reports the single highest-priority enabled source in the identification register. It drives an interrupt pin gated by a general-purpose modem control bit. It also supplies the reset values of every register and every modem output.

The serial shift engines, the baud generator and any FIFO sit outside this block. It hands them the transmit byte, the divisor and a break-gated serial line.

Top module: `sio_host_regs`

## Requirements
- R1: With line control bit 7 at 0, a write to address 0 loads the transmit byte (`tx_data`) and pulses `tx_wr`, a read of address 0 returns the receive buffer, and address 1 reads and writes the interrupt enable register, whose bits 7..4 always read 0.
- R2: With line control bit 7 at 1, address 0 holds divisor bits 7..0 and address 1 holds divisor bits 15..8, both visible on `dl_out`. Only a write to the line control register changes that bit.
- R3: Addresses 2 to 7 ignore line control bit 7. They select identification (read only), line control, modem control, line status, modem status and scratch, in that order.
- R4: After reset: interrupt enable, line control and modem control read 0, identification reads 0x01, line status reads 0x60, and modem status bits 3..0 read 0.
- R5: Reset drives `sout`, `dtr_n`, `rts_n`, `out1_n` and `out2_n` high. It leaves scratch, divisor, receive buffer and transmit byte unchanged.
- R6: Modem control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n` inverted. Modem control bits 7..4 read 0.
- R7: Modem status bits 4, 5, 6 and 7 show the inverted `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. Bits 0 to 3 are sticky change flags for the same pins, set one cycle after a pin changes and cleared by a modem status read. If any of them is set, a modem event is pending.
- R8: `ev_rx_avail` captures `rx_data` into the receive buffer and sets the data-available flag, shown in line status bit 0. A receive buffer read clears it.
- R9: `ev_rx_err` ORs `rx_err_code` into line status bits 4..1 and sets the receive-error flag. A line status read clears both.
- R10: `ev_tx_empty` sets the transmit-empty flag and line status bits 5 and 6. A transmit write clears both. An identification read clears the flag only when that read reports transmit-empty as the source.
- R11: Identification bit 0 is 0 whenever an enabled source is pending. Bits 2..1 name the highest-priority enabled source: 11 receive error, 10 data available, 01 transmit empty, 00 modem change, in that priority order. Interrupt enable bits 0, 1, 2 and 3 enable data available, transmit empty, receive error and modem change.
- R12: `irq` is high when any enabled source is pending and modem control bit 3 is 1. It is low while reset is active.
- R13: `sout` is registered: one cycle after an edge it equals `tx_serial` forced low while line control bit 6 (break) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access; read side effects apply at the edge |
| host_rdata | output | 8 | Read data for the addressed register (combinational) |
| rx_data | input | 8 | Byte from the receiver |
| ev_rx_avail | input | 1 | Receiver has a byte |
| rx_err_code | input | 4 | Receiver error bits |
| ev_rx_err | input | 1 | Receiver error event |
| ev_tx_empty | input | 1 | Transmitter took the held byte |
| tx_data | output | 8 | Transmit byte |
| tx_wr | output | 1 | Transmit byte written this cycle |
| tx_serial | input | 1 | Serial bit from the transmitter |
| sout | output | 1 | Serial output line |
| dl_out | output | 16 | Baud divisor |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq | output | 1 | Interrupt request |

## Verification
The tests exercise address decoding with the access bit in both states. Shared addresses give different contents in each state, and scratch and line control read the same in both, which shows that the upper six addresses ignore the bit. Interrupt tests raise one source at a time to match each identification code with its clearing access. Sources are also raised in pairs. This shows the priority order, and it shows that an identification read leaves a transmit-empty flag that is hidden behind another source. A reset in the middle of a run, after values have been written, separates the registers that reset from those that keep their contents.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
   localparam logic [2:0] ADR_BUF = 3'd0;
   localparam logic [2:0] ADR_IER = 3'd1;
   localparam logic [2:0] ADR_IIR = 3'd2;
   localparam logic [2:0] ADR_LCR = 3'd3;
   localparam logic [2:0] ADR_MCR = 3'd4;
   localparam logic [2:0] ADR_LSR = 3'd5;
   localparam logic [2:0] ADR_MSR = 3'd6;
   localparam logic [2:0] ADR_SCR = 3'd7;

   typedef enum logic [3:0] {
      SEL_BUF, SEL_IER, SEL_DLO, SEL_DHI, SEL_IIR,
      SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
   } reg_sel_e;

   // flag slots in the pending vector
   localparam int FL_RXAV = 0;
   localparam int FL_TXE  = 1;
   localparam int FL_RERR = 2;
   localparam int FL_NUM  = 3;
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
   import sio_regs_pkg::*;
(
   input  logic [2:0] addr,
   input  logic       dlab,
   output reg_sel_e   sel
);
   always_comb begin
      unique case (addr)
         ADR_BUF: sel = dlab ? SEL_DLO : SEL_BUF;
         ADR_IER: sel = dlab ? SEL_DHI : SEL_IER;
         ADR_IIR: sel = SEL_IIR;
         ADR_LCR: sel = SEL_LCR;
         ADR_MCR: sel = SEL_MCR;
         ADR_LSR: sel = SEL_LSR;
         ADR_MSR: sel = SEL_MSR;
         default: sel = SEL_SCR;
      endcase
   end
endmodule

// File: rtl/sio_irq_flags.sv
module sio_irq_flags #(
   parameter int NFLAGS   = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NFLAGS-1:0] set_i,
   input  logic [NFLAGS-1:0] clr_i,
   output logic [NFLAGS-1:0] flag_o
);
   if (NFLAGS < 1) begin : g_bad_n
      $error("sio_irq_flags: NFLAGS must be at least 1");
   end

   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst) begin
            flag_o[i] <= 1'b0;
         end else if (SET_WINS) begin
            flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
         end else begin
            flag_o[i] <= (set_i[i] | flag_o[i]) & ~clr_i[i];
         end
      end

      if (SET_WINS) begin : g_set_chk
         // R8 R9 R10: an event is never lost
         p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_o[i]);
      end
      // R8 R9 R10: the clearing access removes the flag
      p_flag_clr_r9: assert property (@(posedge clk) disable iff (rst)
         (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
   end
endmodule

// File: rtl/sio_modem_status.sv
module sio_modem_status #(
   parameter int NLINES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NLINES-1:0] pins_n,
   input  logic              rd_clr,
   output logic [NLINES-1:0] delta_o,
   output logic [NLINES-1:0] level_o
);
   logic [NLINES-1:0] prev_n;

   if (NLINES < 1) begin : g_bad_n
      $error("sio_modem_status: NLINES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_n  <= pins_n;
         delta_o <= '0;
      end else begin
         prev_n  <= pins_n;
         delta_o <= (delta_o & ~{NLINES{rd_clr}}) | (prev_n ^ pins_n);
      end
   end

   assign level_o = ~pins_n;

   for (genvar i = 0; i < NLINES; i++) begin : g_chk
      // R7: a pin change is always caught, even against a status read
      p_delta_catch_r7: assert property (@(posedge clk) disable iff (rst)
         (pins_n[i] != prev_n[i]) |=> delta_o[i]);
   end
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
   import sio_regs_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ERR_W    = 4,
   parameter int NLINES   = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [2:0]          host_addr,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic                host_wr,
   input  logic                host_rd,
   output logic [DATA_W-1:0]   host_rdata,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic                ev_rx_avail,
   input  logic [ERR_W-1:0]    rx_err_code,
   input  logic                ev_rx_err,
   input  logic                ev_tx_empty,
   output logic [DATA_W-1:0]   tx_data,
   output logic                tx_wr,
   input  logic                tx_serial,
   output logic                sout,
   output logic [2*DATA_W-1:0] dl_out,
   input  logic                cts_n,
   input  logic                dsr_n,
   input  logic                ri_n,
   input  logic                dcd_n,
   output logic                dtr_n,
   output logic                rts_n,
   output logic                out1_n,
   output logic                out2_n,
   output logic                irq
);
   localparam int NSRC = FL_NUM + 1;

   if (DATA_W != 8) begin : g_bad_w
      $error("sio_host_regs: DATA_W must be 8");
   end
   if (ERR_W != 4 || NLINES != 4) begin : g_bad_fields
      $error("sio_host_regs: ERR_W and NLINES must be 4");
   end

   reg_sel_e          sel;
   logic [3:0]        ier;
   logic [7:0]        lcr;
   logic [3:0]        mcr;
   logic [7:0]        scr, dlo, dhi, rbr, thr;
   logic [3:0]        lsr_err;
   logic              thre, sout_q;
   logic [FL_NUM-1:0] fl_set, fl_clr, flags;
   logic [3:0]        mdelta, mlevel;
   logic [NSRC-1:0]   pend;
   logic [2:0]        iir_lo;
   logic              wr_buf, rd_buf, rd_iir, rd_lsr, rd_msr, iir_is_tx;

   sio_addr_decode u_dec (.addr(host_addr), .dlab(lcr[7]), .sel(sel));

   assign wr_buf = host_wr && sel == SEL_BUF;
   assign rd_buf = host_rd && sel == SEL_BUF;
   assign rd_iir = host_rd && sel == SEL_IIR;
   assign rd_lsr = host_rd && sel == SEL_LSR;
   assign rd_msr = host_rd && sel == SEL_MSR;

   // registers that reset
   always_ff @(posedge clk) begin
      if (rst) begin
         ier     <= '0;
         lcr     <= '0;
         mcr     <= '0;
         lsr_err <= '0;
         thre    <= 1'b1;
         sout_q  <= 1'b1;
      end else begin
         if (host_wr && sel == SEL_IER) ier <= host_wdata[3:0];
         if (host_wr && sel == SEL_LCR) lcr <= host_wdata;
         if (host_wr && sel == SEL_MCR) mcr <= host_wdata[3:0];
         if (ev_rx_err)   lsr_err <= lsr_err | rx_err_code;
         else if (rd_lsr) lsr_err <= '0;
         if (wr_buf)           thre <= 1'b0;
         else if (ev_tx_empty) thre <= 1'b1;
         sout_q <= tx_serial & ~lcr[6];
      end
   end

   // registers that keep their contents through reset
   always_ff @(posedge clk) begin
      if (host_wr && sel == SEL_SCR) scr <= host_wdata;
      if (host_wr && sel == SEL_DLO) dlo <= host_wdata;
      if (host_wr && sel == SEL_DHI) dhi <= host_wdata;
      if (wr_buf)      thr <= host_wdata;
      if (ev_rx_avail) rbr <= rx_data;
   end

   // interrupt sources
   assign fl_set[FL_RXAV] = ev_rx_avail;
   assign fl_set[FL_TXE]  = ev_tx_empty;
   assign fl_set[FL_RERR] = ev_rx_err;
   assign fl_clr[FL_RXAV] = rd_buf;
   assign fl_clr[FL_TXE]  = wr_buf | (rd_iir & iir_is_tx);
   assign fl_clr[FL_RERR] = rd_lsr;

   sio_irq_flags #(.NFLAGS(FL_NUM), .SET_WINS(SET_WINS)) u_flags (
      .clk(clk), .rst(rst), .set_i(fl_set), .clr_i(fl_clr), .flag_o(flags)
   );

   sio_modem_status #(.NLINES(NLINES)) u_msr (
      .clk(clk), .rst(rst), .pins_n({dcd_n, ri_n, dsr_n, cts_n}),
      .rd_clr(rd_msr), .delta_o(mdelta), .level_o(mlevel)
   );

   // pend bit order follows the enable register
   assign pend = {|mdelta & ier[3], flags[FL_RERR] & ier[2],
                  flags[FL_TXE] & ier[1], flags[FL_RXAV] & ier[0]};

   always_comb begin
      if (pend[2])      iir_lo = 3'b110;
      else if (pend[0]) iir_lo = 3'b100;
      else if (pend[1]) iir_lo = 3'b010;
      else if (pend[3]) iir_lo = 3'b000;
      else              iir_lo = 3'b001;
   end
   assign iir_is_tx = (iir_lo == 3'b010);

   always_comb begin
      unique case (sel)
         SEL_BUF: host_rdata = rbr;
         SEL_IER: host_rdata = {4'h0, ier};
         SEL_DLO: host_rdata = dlo;
         SEL_DHI: host_rdata = dhi;
         SEL_IIR: host_rdata = {5'h00, iir_lo};
         SEL_LCR: host_rdata = lcr;
         SEL_MCR: host_rdata = {4'h0, mcr};
         SEL_LSR: host_rdata = {1'b0, thre, thre, lsr_err, flags[FL_RXAV]};
         SEL_MSR: host_rdata = {mlevel, mdelta};
         default: host_rdata = scr;
      endcase
   end

   assign tx_data = thr;
   assign tx_wr   = wr_buf;
   assign dl_out  = {dhi, dlo};
   assign sout    = sout_q;
   assign dtr_n   = ~mcr[0];
   assign rts_n   = ~mcr[1];
   assign out1_n  = ~mcr[2];
   assign out2_n  = ~mcr[3];
   assign irq     = ~rst & mcr[3] & (|pend);

   // R12: clearing the gate bit silences the pin
   p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_addr == ADR_MCR && !host_wdata[3]) |=> !irq);
   // R2: divisor low byte takes the written value
   p_div_low_r2: assert property (@(posedge clk) disable iff (rst)
      (host_wr && lcr[7] && host_addr == ADR_BUF) |=> dl_out[7:0] == $past(host_wdata));
   // R10: a transmit write empties the holding status
   p_thr_full_r10: assert property (@(posedge clk) disable iff (rst)
      (host_wr && !lcr[7] && host_addr == ADR_BUF) |=> !thre);
endmodule

// File: tb/tb_sio_host_regs.sv
module tb_sio_host_regs;
   logic clk = 1'b0, rst = 1'b1;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata, rx_data = '0, tx_data;
   logic host_wr = 0, host_rd = 0, ev_rx_avail = 0, ev_rx_err = 0, ev_tx_empty = 0;
   logic [3:0] rx_err_code = '0;
   logic tx_wr, tx_serial = 1'b1, sout, irq;
   logic [15:0] dl_out;
   logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
   logic dtr_n, rts_n, out1_n, out2_n;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sio_host_regs dut (.*);

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
      @(negedge clk); host_wr = 0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
      @(negedge clk); host_rd = 0;
   endtask

   task automatic peek(logic [2:0] a, output logic [7:0] d);
      @(negedge clk); host_addr = a; #1 d = host_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      #1 chk("R12 irq low in reset", irq, 0);
      @(negedge clk); @(negedge clk); rst = 0;
   endtask

   task automatic t_reset_values();
      logic [7:0] v;
      @(negedge clk); #1 chk("R5 sout high", sout, 1);
      chk("R5 modem pins high", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
      peek(1, v); chk("R4 IER", v, 8'h00);
      peek(2, v); chk("R4 IIR", v, 8'h01);
      peek(3, v); chk("R4 LCR", v, 8'h00);
      peek(4, v); chk("R4 MCR", v, 8'h00);
      peek(5, v); chk("R4 LSR", v, 8'h60);
      peek(6, v); chk("R4 MSR", v, 8'h00);
      chk("R12 irq idle", irq, 0);
   endtask

   task automatic t_address_map();
      logic [7:0] v;
      wr(1, 8'hFF); peek(1, v); chk("R1 IER upper bits read 0", v, 8'h0F);
      wr(1, 8'h00);
      wr(3, 8'h83);
      wr(0, 8'h34); wr(1, 8'h12);
      chk("R2 divisor", dl_out, 16'h1234);
      peek(0, v); chk("R2 divisor low read", v, 8'h34);
      wr(7, 8'h5A); peek(7, v); chk("R3 scratch with bit7 set", v, 8'h5A);
      peek(3, v); chk("R3 LCR with bit7 set", v, 8'h83);
      wr(3, 8'h03);
      wr(0, 8'h55);
      chk("R1 transmit byte", tx_data, 8'h55);
      chk("R2 divisor untouched by bit7=0 write", dl_out, 16'h1234);
      peek(1, v); chk("R1 addr1 is IER when bit7 clear", v, 8'h00);
      peek(7, v); chk("R3 scratch with bit7 clear", v, 8'h5A);
      peek(2, v); wr(2, 8'hFF); peek(2, v); chk("R3 IIR read only", v, 8'h01);
   endtask

   task automatic t_reset_keep();
      logic [7:0] v;
      wr(7, 8'hA5); wr(3, 8'h40);
      do_reset();
      peek(7, v); chk("R5 scratch kept", v, 8'hA5);
      chk("R5 divisor kept", dl_out, 16'h1234);
      chk("R5 transmit byte kept", tx_data, 8'h55);
      peek(3, v); chk("R4 LCR cleared by reset", v, 8'h00);
   endtask

   task automatic t_modem_ctrl_sout();
      logic [7:0] v;
      wr(4, 8'hFF); peek(4, v); chk("R6 MCR upper bits read 0", v, 8'h0F);
      chk("R6 pins low", {dtr_n, rts_n, out1_n, out2_n}, 4'h0);
      wr(4, 8'h02); chk("R6 rts only", {dtr_n, rts_n, out1_n, out2_n}, 4'hB);
      wr(3, 8'h40); @(negedge clk); chk("R13 break forces sout low", sout, 0);
      wr(3, 8'h00); @(negedge clk); chk("R13 sout follows line", sout, 1);
      tx_serial = 0; @(negedge clk); chk("R13 sout follows zero", sout, 0);
      tx_serial = 1; @(negedge clk);
      wr(4, 8'h00);
   endtask

   task automatic t_rx_and_error();
      logic [7:0] v;
      wr(1, 8'h05); wr(4, 8'h08);
      @(negedge clk); rx_data = 8'h3C; ev_rx_avail = 1;
      @(negedge clk); ev_rx_avail = 0;
      peek(2, v); chk("R11 data available code", v, 8'h04);
      chk("R12 irq with source", irq, 1);
      @(negedge clk); rx_err_code = 4'hA; ev_rx_err = 1;
      @(negedge clk); ev_rx_err = 0;
      peek(5, v); chk("R9 LSR error bits and ready", v & 8'h1F, 8'h15);
      peek(2, v); chk("R11 error outranks data", v, 8'h06);
      rd(5, v);
      peek(5, v); chk("R9 LSR read clears errors", v & 8'h1F, 8'h01);
      peek(2, v); chk("R9 error flag cleared", v, 8'h04);
      rd(0, v); chk("R8 receive buffer", v, 8'h3C);
      peek(2, v); chk("R8 read clears data flag", v, 8'h01);
      chk("R12 irq drops", irq, 0);
   endtask

   task automatic t_tx_empty();
      logic [7:0] v;
      wr(1, 8'h02);
      @(negedge clk); ev_tx_empty = 1; @(negedge clk); ev_tx_empty = 0;
      peek(5, v); chk("R10 LSR empty bits", v & 8'h60, 8'h60);
      rd(2, v); chk("R11 transmit empty code", v, 8'h02);
      peek(2, v); chk("R10 IIR read clears tx flag", v, 8'h01);
      @(negedge clk); ev_tx_empty = 1; @(negedge clk); ev_tx_empty = 0;
      wr(0, 8'h77);
      peek(2, v); chk("R10 write clears tx flag", v, 8'h01);
      peek(5, v); chk("R10 write clears LSR empty", v & 8'h60, 8'h00);
      chk("R1 transmit byte 2", tx_data, 8'h77);
      wr(1, 8'h03);
      @(negedge clk); ev_tx_empty = 1; rx_data = 8'h11; ev_rx_avail = 1;
      @(negedge clk); ev_tx_empty = 0; ev_rx_avail = 0;
      rd(2, v); chk("R11 data outranks tx", v, 8'h04);
      rd(0, v);
      peek(2, v); chk("R10 hidden tx flag survives IIR read", v, 8'h02);
      rd(2, v);
   endtask

   task automatic t_gate();
      logic [7:0] v;
      wr(4, 8'h00); wr(1, 8'h01);
      @(negedge clk); ev_rx_avail = 1; @(negedge clk); ev_rx_avail = 0;
      #1 chk("R12 gate off holds irq low", irq, 0);
      peek(2, v); chk("R11 pending while gated", v, 8'h04);
      wr(4, 8'h08); #1 chk("R12 gate on raises irq", irq, 1);
      wr(1, 8'h00); #1 chk("R11 disabled source not reported", irq, 0);
      rd(0, v);
   endtask

   task automatic t_modem();
      logic [7:0] v;
      wr(1, 8'h08); wr(4, 8'h08);
      @(negedge clk); cts_n = 0;
      @(negedge clk);
      peek(6, v); chk("R7 CTS level and delta", v, 8'h11);
      peek(2, v); chk("R11 modem code", v, 8'h00);
      rd(6, v);
      peek(6, v); chk("R7 read clears delta", v, 8'h10);
      peek(2, v); chk("R7 modem flag cleared", v, 8'h01);
      @(negedge clk); dcd_n = 0; ri_n = 0;
      @(negedge clk);
      peek(6, v); chk("R7 DCD RI delta", v, 8'hDC);
      rd(6, v);
      wr(1, 8'h00); wr(4, 8'h00);
   endtask

   initial begin
      do_reset();
      t_reset_values();
      t_address_map();
      t_reset_keep();
      t_modem_ctrl_sout();
      t_rx_and_error();
      t_tx_empty();
      t_gate();
      t_modem();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule